// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar date as packed BCD bytes. A one-cycle enable pulse, produced elsewhere once per second, moves the seconds forward. Carries ripple through minutes, hours, day of week, day of month, month and year in that same clock edge. The hours byte runs either from 00 to 23 or as a 12-hour clock in which bit 7 marks PM. A mode input selects the format and also sets the meaning of the hours alarm byte.

Software presets any counter or alarm byte through a single load port: a strobe, a 4-bit selector and a data byte. On each second step the block compares the new seconds, minutes and hours against three alarm bytes. When all three agree it raises a sticky alarm flag. An alarm byte whose two top bits are both set acts as a wildcard, so three wildcards give an alarm every second.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the outputs read 12:00:00 (hour byte 0x12), day of week 0x01, day of month 0x01, month 0x01, year 0x00, and the alarm flag is low.
- R2: With the load strobe high, the selector picks the target byte: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 8 seconds alarm, 9 minutes alarm, 10 hours alarm. The data appears on the next edge. Any other selector value changes nothing. In a load cycle the second pulse is dropped.
- R3: Without a second pulse and without a load, no counter output changes.
- R4: Seconds and minutes count in BCD from 0x00 to 0x59. On leaving 0x59 a byte returns to 0x00 and carries into the next byte, and the low digit carries into the high digit after 9.
- R5: With the mode input low, hours count 0x00 to 0x23. Leaving 23:59:59 gives 00:00:00 and advances the date.
- R6: With the mode input high, hours count 01–12 with bit 7 as PM. 0x11 steps to 0x92, 0x92 steps to 0x81, and 0x12 steps to 0x01. Leaving 0x91 (11 PM) gives 0x12 (12 AM) and advances the date.
- R7: Each date advance steps the day of week, with 0x07 wrapping to 0x01.
- R8: The day of month wraps to 0x01 and the month advances after day 0x30 in months 04, 06, 09 and 11, and after day 0x31 in the other months. February ends on day 0x29 when the year's value is divisible by four and on day 0x28 otherwise.
- R9: Month 0x12 wraps to 0x01 and advances the year, and year 0x99 wraps to 0x00.
- R10: On a second step the alarm flag is set at the same edge as the counters when the updated seconds, minutes and hours each match their alarm byte. A step that does not match leaves the flag unchanged.
- R11: An alarm byte in the range 0xC0–0xFF matches any counter value.
- R12: The alarm flag stays high until the clear input is pulsed. A matching step in the same cycle as a clear leaves the flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| hr12_i | input | 1 | Hour format: 1 selects 12-hour with PM in bit 7, 0 selects 24-hour |
| ld_en_i | input | 1 | Load strobe |
| ld_sel_i | input | 4 | Load target selector (codes in R2) |
| ld_data_i | input | 8 | Load data, packed BCD |
| alarm_clr_i | input | 1 | Clears the alarm flag |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD; bit 7 is PM in 12-hour format |
| dow_o | output | 8 | Day of week, BCD 01–07 |
| dom_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD 00–99 |
| alarm_o | output | 1 | Sticky alarm flag |

## Verification
A wrong digit or a lost carry in the time chain shows on the counter outputs one edge after the second pulse that caused it. A month-length or leap error stays hidden until a date advance and then shows as a wrong day or month byte. The bench therefore presets the counters to the last second before each rollover and checks every byte right after the single step that crosses it. A mismatch in the alarm compare shows in the flag at that same edge, and a flag that fails to hold or to clear shows on the very next idle or clear cycle.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int unsigned CAL_BYTE_W = 8;

   typedef enum logic [3:0] {
      SEL_SEC   = 4'd0,
      SEL_MIN   = 4'd1,
      SEL_HOUR  = 4'd2,
      SEL_DOW   = 4'd3,
      SEL_DOM   = 4'd4,
      SEL_MON   = 4'd5,
      SEL_YEAR  = 4'd6,
      SEL_ASEC  = 4'd8,
      SEL_AMIN  = 4'd9,
      SEL_AHOUR = 4'd10
   } cal_sel_e;

   // Add one to a two-digit packed BCD value.
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // Last day of a month (BCD) for a given BCD month and BCD year.
   function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02: return ((({4'd0, yr[7:4]} * 8'd10 + {4'd0, yr[3:0]}) % 8'd4) == 8'd0)
                       ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default: return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
   import rtc_cal_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              adv_i,
   input  logic              hr12_i,
   input  logic              wr_sec_i,
   input  logic              wr_min_i,
   input  logic              wr_hour_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   output logic [BYTE_W-1:0] sec_o,
   output logic [BYTE_W-1:0] min_o,
   output logic [BYTE_W-1:0] hour_o,
   output logic [BYTE_W-1:0] sec_nxt_o,
   output logic [BYTE_W-1:0] min_nxt_o,
   output logic [BYTE_W-1:0] hour_nxt_o,
   output logic              day_carry_o
);

   logic [BYTE_W-1:0] sec_q, min_q, hour_q;
   logic [BYTE_W-1:0] hour_step;
   logic              sec_wrap, min_wrap, end_of_day;

   assign sec_wrap = (sec_q == 8'h59);
   assign min_wrap = (min_q == 8'h59);

   always_comb begin
      hour_step  = hour_q;
      end_of_day = 1'b0;
      if (hr12_i) begin
         case (hour_q[6:0])
            7'h11: begin
               hour_step  = {~hour_q[7], 7'h12};
               end_of_day = hour_q[7];
            end
            7'h12:   hour_step = {hour_q[7], 7'h01};
            default: hour_step = {hour_q[7], 7'h00} | bcd_inc({1'b0, hour_q[6:0]});
         endcase
      end else if (hour_q == 8'h23) begin
         hour_step  = 8'h00;
         end_of_day = 1'b1;
      end else begin
         hour_step = bcd_inc(hour_q);
      end
   end

   always_comb begin
      sec_nxt_o  = sec_q;
      min_nxt_o  = min_q;
      hour_nxt_o = hour_q;
      if (adv_i) begin
         sec_nxt_o = sec_wrap ? 8'h00 : bcd_inc(sec_q);
         if (sec_wrap) begin
            min_nxt_o = min_wrap ? 8'h00 : bcd_inc(min_q);
            if (min_wrap) hour_nxt_o = hour_step;
         end
      end
   end

   assign day_carry_o = adv_i & sec_wrap & min_wrap & end_of_day;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sec_q  <= 8'h00;
         min_q  <= 8'h00;
         hour_q <= 8'h12;
      end else begin
         sec_q  <= wr_sec_i  ? wr_data_i : sec_nxt_o;
         min_q  <= wr_min_i  ? wr_data_i : min_nxt_o;
         hour_q <= wr_hour_i ? wr_data_i : hour_nxt_o;
      end
   end

   assign sec_o  = sec_q;
   assign min_o  = min_q;
   assign hour_o = hour_q;

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
   import rtc_cal_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              day_step_i,
   input  logic              wr_dow_i,
   input  logic              wr_dom_i,
   input  logic              wr_mon_i,
   input  logic              wr_year_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   output logic [BYTE_W-1:0] dow_o,
   output logic [BYTE_W-1:0] dom_o,
   output logic [BYTE_W-1:0] mon_o,
   output logic [BYTE_W-1:0] year_o
);

   logic [BYTE_W-1:0] dow_q, dom_q, mon_q, year_q;
   logic [BYTE_W-1:0] dow_n, dom_n, mon_n, year_n;
   logic              month_end;

   assign month_end = (dom_q == month_last(mon_q, year_q));

   always_comb begin
      dow_n  = dow_q;
      dom_n  = dom_q;
      mon_n  = mon_q;
      year_n = year_q;
      if (day_step_i) begin
         dow_n = (dow_q == 8'h07) ? 8'h01 : bcd_inc(dow_q);
         dom_n = month_end ? 8'h01 : bcd_inc(dom_q);
         if (month_end) begin
            mon_n = (mon_q == 8'h12) ? 8'h01 : bcd_inc(mon_q);
            if (mon_q == 8'h12) year_n = (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dow_q  <= 8'h01;
         dom_q  <= 8'h01;
         mon_q  <= 8'h01;
         year_q <= 8'h00;
      end else begin
         dow_q  <= wr_dow_i  ? wr_data_i : dow_n;
         dom_q  <= wr_dom_i  ? wr_data_i : dom_n;
         mon_q  <= wr_mon_i  ? wr_data_i : mon_n;
         year_q <= wr_year_i ? wr_data_i : year_n;
      end
   end

   assign dow_o  = dow_q;
   assign dom_o  = dom_q;
   assign mon_o  = mon_q;
   assign year_o = year_q;

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
   parameter int unsigned BYTE_W         = 8,
   parameter int unsigned NUM_FIELDS     = 3,
   parameter bit          ALARM_WILDCARD = 1'b1
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic [NUM_FIELDS-1:0]             wr_i,
   input  logic [BYTE_W-1:0]                 wr_data_i,
   input  logic                              eval_i,
   input  logic                              clr_i,
   input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] cur_i,
   output logic                              flag_o
);

   logic [BYTE_W-1:0]     alm_q [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] hit;
   logic                  flag_q;

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      alm_q[i] <= '0;
         else if (wr_i[i]) alm_q[i] <= wr_data_i;
      end
      if (ALARM_WILDCARD) begin : g_wild
         assign hit[i] = (alm_q[i][BYTE_W-1 -: 2] == 2'b11) || (alm_q[i] == cur_i[i]);
      end else begin : g_exact
         assign hit[i] = (alm_q[i] == cur_i[i]);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              flag_q <= 1'b0;
      else if (eval_i && &hit)  flag_q <= 1'b1;
      else if (clr_i)           flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
   import rtc_cal_pkg::*;
#(
   parameter int unsigned BYTE_W         = 8,
   parameter int unsigned SEL_W          = 4,
   parameter bit          ALARM_WILDCARD = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              hr12_i,
   input  logic              ld_en_i,
   input  logic [SEL_W-1:0]  ld_sel_i,
   input  logic [BYTE_W-1:0] ld_data_i,
   input  logic              alarm_clr_i,
   output logic [BYTE_W-1:0] sec_o,
   output logic [BYTE_W-1:0] min_o,
   output logic [BYTE_W-1:0] hour_o,
   output logic [BYTE_W-1:0] dow_o,
   output logic [BYTE_W-1:0] dom_o,
   output logic [BYTE_W-1:0] mon_o,
   output logic [BYTE_W-1:0] year_o,
   output logic              alarm_o
);

   localparam int unsigned ALM_FIELDS = 3;

   if (BYTE_W != CAL_BYTE_W) begin : g_bad_byte_w
      $error("rtc_bcd_calendar: BYTE_W must equal 8 for two-digit BCD");
   end
   if (SEL_W != 4) begin : g_bad_sel_w
      $error("rtc_bcd_calendar: SEL_W must equal 4");
   end

   logic              adv, day_carry;
   logic [BYTE_W-1:0] sec_nxt, min_nxt, hour_nxt;
   logic [ALM_FIELDS-1:0] wr_alm;

   function automatic logic sel_hit(input logic [SEL_W-1:0] s, input cal_sel_e code);
      return ld_en_i && (s == SEL_W'(code));
   endfunction

   assign adv    = tick_i & ~ld_en_i;
   assign wr_alm = {sel_hit(ld_sel_i, SEL_AHOUR), sel_hit(ld_sel_i, SEL_AMIN),
                    sel_hit(ld_sel_i, SEL_ASEC)};

   rtc_time_chain #(.BYTE_W(BYTE_W)) u_time (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .adv_i       (adv),
      .hr12_i      (hr12_i),
      .wr_sec_i    (sel_hit(ld_sel_i, SEL_SEC)),
      .wr_min_i    (sel_hit(ld_sel_i, SEL_MIN)),
      .wr_hour_i   (sel_hit(ld_sel_i, SEL_HOUR)),
      .wr_data_i   (ld_data_i),
      .sec_o       (sec_o),
      .min_o       (min_o),
      .hour_o      (hour_o),
      .sec_nxt_o   (sec_nxt),
      .min_nxt_o   (min_nxt),
      .hour_nxt_o  (hour_nxt),
      .day_carry_o (day_carry)
   );

   rtc_date_chain #(.BYTE_W(BYTE_W)) u_date (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .day_step_i (day_carry),
      .wr_dow_i   (sel_hit(ld_sel_i, SEL_DOW)),
      .wr_dom_i   (sel_hit(ld_sel_i, SEL_DOM)),
      .wr_mon_i   (sel_hit(ld_sel_i, SEL_MON)),
      .wr_year_i  (sel_hit(ld_sel_i, SEL_YEAR)),
      .wr_data_i  (ld_data_i),
      .dow_o      (dow_o),
      .dom_o      (dom_o),
      .mon_o      (mon_o),
      .year_o     (year_o)
   );

   rtc_alarm_unit #(
      .BYTE_W         (BYTE_W),
      .NUM_FIELDS     (ALM_FIELDS),
      .ALARM_WILDCARD (ALARM_WILDCARD)
   ) u_alarm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_alm),
      .wr_data_i (ld_data_i),
      .eval_i    (adv),
      .clr_i     (alarm_clr_i),
      .cur_i     ({hour_nxt, min_nxt, sec_nxt}),
      .flag_o    (alarm_o)
   );

endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       tick_i,
   input logic       hr12_i,
   input logic       ld_en_i,
   input logic [3:0] ld_sel_i,
   input logic [7:0] ld_data_i,
   input logic       alarm_clr_i,
   input logic [7:0] sec_o,
   input logic [7:0] min_o,
   input logic [7:0] hour_o,
   input logic [7:0] dow_o,
   input logic [7:0] dom_o,
   input logic [7:0] mon_o,
   input logic [7:0] year_o,
   input logic       alarm_o
);

   logic step, last_second;
   assign step        = tick_i && !ld_en_i;
   assign last_second = (sec_o == 8'h59) && (min_o == 8'h59) &&
                        (hr12_i ? (hour_o == 8'h91) : (hour_o == 8'h23));

   // R2
   load_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_en_i && ld_sel_i == 4'd0 |=> sec_o == $past(ld_data_i));

   // R3
   hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i && !ld_en_i |=> $stable({sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o}));

   // R4
   sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step && sec_o == 8'h59 |=> sec_o == 8'h00);

   // R6
   pm_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step && hr12_i && hour_o == 8'h11 && min_o == 8'h59 && sec_o == 8'h59 |=> hour_o == 8'h92);

   // R7
   dow_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step && last_second && dow_o == 8'h07 |=> dow_o == 8'h01);

   // R9
   year_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step && last_second && mon_o == 8'h12 && dom_o == 8'h31 && year_o == 8'h99
      |=> year_o == 8'h00 && mon_o == 8'h01 && dom_o == 8'h01);

   // R10
   flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !alarm_o && !step |=> !alarm_o);

   // R12
   flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alarm_o && !alarm_clr_i |=> alarm_o);

   // R12
   flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alarm_clr_i && !tick_i |=> !alarm_o);

endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .tick_i      (tick_i),
   .hr12_i      (hr12_i),
   .ld_en_i     (ld_en_i),
   .ld_sel_i    (ld_sel_i),
   .ld_data_i   (ld_data_i),
   .alarm_clr_i (alarm_clr_i),
   .sec_o       (sec_o),
   .min_o       (min_o),
   .hour_o      (hour_o),
   .dow_o       (dow_o),
   .dom_o       (dom_o),
   .mon_o       (mon_o),
   .year_o      (year_o),
   .alarm_o     (alarm_o)
);

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;

   localparam int CLK_P = 10;

   typedef struct {
      logic [7:0] sec, min, hour, dow, dom, mon, yr;
      logic       flag;
      string      req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, hr12 = 1'b0, ld_en = 1'b0, clr = 1'b0;
   logic [3:0] ld_sel = '0;
   logic [7:0] ld_data = '0;
   logic [7:0] sec, min, hour, dow, dom, mon, yr;
   logic       alarm;

   int   checks = 0, errors = 0;
   bit   done = 1'b0;
   exp_t q[$];
   exp_t e, got;

   always #(CLK_P/2) clk = ~clk;

   rtc_bcd_calendar u_dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .hr12_i(hr12),
      .ld_en_i(ld_en), .ld_sel_i(ld_sel), .ld_data_i(ld_data), .alarm_clr_i(clr),
      .sec_o(sec), .min_o(min), .hour_o(hour), .dow_o(dow), .dom_o(dom),
      .mon_o(mon), .year_o(yr), .alarm_o(alarm)
   );

   // Monitor: each queued item is due a quarter period after the next rising edge.
   always @(posedge clk) begin
      #(CLK_P/4);
      if (q.size() > 0) begin
         got = q.pop_front();
         checks++;
         if ({sec, min, hour, dow, dom, mon, yr, alarm} !==
             {got.sec, got.min, got.hour, got.dow, got.dom, got.mon, got.yr, got.flag}) begin
            errors++;
            $display("FAIL %s: actual %h:%h:%h dow%h %h/%h/%h flag%b, expected %h:%h:%h dow%h %h/%h/%h flag%b",
                     got.req, hour, min, sec, dow, dom, mon, yr, alarm,
                     got.hour, got.min, got.sec, got.dow, got.dom, got.mon, got.yr, got.flag);
         end
      end
   end

   task automatic cyc(input bit t, input bit l, input logic [3:0] s, input logic [7:0] d,
                      input bit c, input bit chk, input string req);
      exp_t x;
      @(negedge clk);
      tick = t; ld_en = l; ld_sel = s; ld_data = d; clr = c;
      if (chk) begin
         x = e; x.req = req;
         q.push_back(x);
      end
   endtask

   task automatic ld(input logic [3:0] s, input logic [7:0] d);
      case (s)
         4'd0: e.sec  = d;
         4'd1: e.min  = d;
         4'd2: e.hour = d;
         4'd3: e.dow  = d;
         4'd4: e.dom  = d;
         4'd5: e.mon  = d;
         4'd6: e.yr   = d;
         default: ;
      endcase
      cyc(1'b0, 1'b1, s, d, 1'b0, 1'b0, "");
   endtask

   task automatic step_chk(input string req);
      cyc(1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 1'b1, req);
   endtask

   task automatic idle_chk(input string req);
      cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b1, req);
   endtask

   task automatic set_mode(input bit m);
      @(negedge clk);
      tick = 1'b0; ld_en = 1'b0; clr = 1'b0; hr12 = m;
   endtask

   task automatic last_sec(input logic [7:0] h);
      ld(4'd2, h); ld(4'd1, 8'h59); ld(4'd0, 8'h59);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      e = '{sec:8'h00, min:8'h00, hour:8'h12, dow:8'h01, dom:8'h01, mon:8'h01,
            yr:8'h00, flag:1'b0, req:""};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle_chk("R1 reset state");
      idle_chk("R3 no pulse, no change");

      // Keep the hours alarm away from the times used below.
      ld(4'd10, 8'h20);

      // 24-hour rollover at the end of a non-leap February.
      ld(4'd6, 8'h23); ld(4'd5, 8'h02); ld(4'd4, 8'h28); ld(4'd3, 8'h07);
      ld(4'd2, 8'h23); ld(4'd1, 8'h59); ld(4'd0, 8'h58);
      idle_chk("R2 loaded bytes");
      e.sec = 8'h59;
      step_chk("R4 seconds count");
      e.sec = 8'h00; e.min = 8'h00; e.hour = 8'h00;
      e.dow = 8'h01; e.dom = 8'h01; e.mon = 8'h03;
      step_chk("R5 R7 R8 day rollover");

      // Unused selector and a load that coincides with a pulse.
      ld(4'd7, 8'h55);
      idle_chk("R2 unused selector");
      e.sec = 8'h30;
      cyc(1'b1, 1'b1, 4'd0, 8'h30, 1'b0, 1'b1, "R2 load drops pulse");

      // Digit carry in hours.
      last_sec(8'h09);
      e.sec = 8'h00; e.min = 8'h00; e.hour = 8'h10;
      step_chk("R4 R5 digit carry");

      // Leap February.
      ld(4'd6, 8'h24); ld(4'd5, 8'h02); ld(4'd4, 8'h28);
      last_sec(8'h23);
      e.sec = 8'h00; e.min = 8'h00; e.hour = 8'h00; e.dom = 8'h29; e.dow = 8'h02;
      step_chk("R8 leap day 29");
      last_sec(8'h23);
      e.sec = 8'h00; e.min = 8'h00; e.hour = 8'h00; e.dom = 8'h01; e.mon = 8'h03; e.dow = 8'h03;
      step_chk("R8 leap February end");

      // 30-day month.
      ld(4'd5, 8'h04); ld(4'd4, 8'h30);
      last_sec(8'h23);
      e.sec = 8'h00; e.min = 8'h00; e.hour = 8'h00; e.dom = 8'h01; e.mon = 8'h05; e.dow = 8'h04;
      step_chk("R8 thirty-day month");

      // Year end.
      ld(4'd6, 8'h99); ld(4'd5, 8'h12); ld(4'd4, 8'h31);
      last_sec(8'h23);
      e.sec = 8'h00; e.min = 8'h00; e.hour = 8'h00; e.dom = 8'h01; e.mon = 8'h01;
      e.yr = 8'h00; e.dow = 8'h05;
      step_chk("R9 year wrap");

      // 12-hour sequence.
      set_mode(1'b1);
      last_sec(8'h11);
      e.sec = 8'h00; e.min = 8'h00; e.hour = 8'h92;
      step_chk("R6 11 AM to 12 PM");
      ld(4'd1, 8'h59); ld(4'd0, 8'h59);
      e.sec = 8'h00; e.min = 8'h00; e.hour = 8'h81;
      step_chk("R6 12 PM to 1 PM");
      last_sec(8'h91);
      e.sec = 8'h00; e.min = 8'h00; e.hour = 8'h12; e.dom = 8'h02; e.dow = 8'h06;
      step_chk("R6 11 PM to 12 AM with date");
      ld(4'd1, 8'h59); ld(4'd0, 8'h59);
      e.sec = 8'h00; e.min = 8'h00; e.hour = 8'h01;
      step_chk("R6 12 AM to 1 AM");

      // Alarm compare.
      set_mode(1'b0);
      ld(4'd2, 8'h10); ld(4'd1, 8'h20); ld(4'd0, 8'h29);
      ld(4'd8, 8'h30); ld(4'd9, 8'h20); ld(4'd10, 8'h10);
      e.sec = 8'h30; e.flag = 1'b1;
      step_chk("R10 alarm match");
      idle_chk("R12 flag holds");
      e.flag = 1'b0;
      cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 1'b1, "R12 clear");
      e.sec = 8'h31;
      step_chk("R10 no match");

      // Wildcards.
      ld(4'd8, 8'hFF); ld(4'd9, 8'hC0); ld(4'd10, 8'hFF);
      e.sec = 8'h32; e.flag = 1'b1;
      step_chk("R11 wildcard match");
      e.sec = 8'h33;
      cyc(1'b1, 1'b0, 4'd0, 8'h00, 1'b1, 1'b1, "R12 set wins over clear");
      e.flag = 1'b0;
      cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 1'b1, "R12 clear after wildcard");
      ld(4'd8, 8'h45);
      e.sec = 8'h34;
      step_chk("R11 one byte exact, no match");

      cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, "");
      repeat (3) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule